// File: doc/BRIEF.md
# Four-Bank DRAM Command Sequencer

This block sits at the front of a DRAM controller. It takes one read or write request at a time, together with a flat word address, and turns it into the command stream that a four-bank synchronous DRAM expects. The flat address is split into a bank, a row and a column. A table records which row is open in each bank.

From that table the block picks the shortest legal sequence for each request:
- a column command alone when the right row is already open;
- an activate followed by the column command when the bank is closed;
- a precharge, then an activate, then the column command when the bank holds another row.

A request may ask for auto precharge, which closes the bank together with the column access. A refresh timer raises a pending refresh at a fixed interval. The sequencer serves it ahead of new work: if any bank is open it first closes all banks with one command, then it issues the refresh.

Command lines are driven as active-low chip select, row strobe, column strobe and write enable, along with the bank and address buses. All timing gaps are counted in clocks. The sequencer drives a no-operation command on every cycle that it spends waiting. Requests use a valid/ready handshake. Ready is high only while the sequencer is idle and no refresh is pending.

Top module: `dram_cmd_seq`

## Requirements
- R1: While reset is held, and on the first cycle after it, the command lines show NOP and `req_ready` is high. Reset is synchronous and active high.
- R2: The flat request address is split as follows: column in bits [8:0], bank in bits [10:9], row in bits [22:11].
- R3: A request to a closed bank issues ACT, with the bank on `ba` and the row on `a`. The READ or WRITE follows exactly T_RCD cycles later, with only NOP between them.
- R4: A request whose row is already open in its bank issues only READ or WRITE, on the cycle after it is accepted.
- R5: A request to a bank holding a different row first issues PRECHARGE to that bank with `a[8]` low. ACT follows exactly T_RP cycles later, and the column command follows T_RCD cycles after that.
- R6: Command codes on {cs_n, ras_n, cas_n, we_n} are NOP 0111, ACT 0011, READ 0101, WRITE 0100, PRECHARGE 0010 and AUTO REFRESH 0001. On READ and WRITE, `a[7:0]` carries column bits [7:0], `a[9]` carries column bit 8, `a[8]` carries the auto-precharge request, and `a[11:10]` are zero.
- R7: A column command sent with auto precharge leaves its bank closed, so the next request to that bank starts with ACT.
- R8: A refresh becomes pending every REF_INT cycles and stays pending until served. While it is pending no new request is accepted, and the AUTO REFRESH goes out within a bounded number of cycles.
- R9: If any bank is open when a refresh is served, the sequencer first issues PRECHARGE with `a[8]` high (all banks). AUTO REFRESH follows exactly T_RP cycles later, and no further command comes earlier than T_RFC cycles after it. When every bank is already closed, the sequencer issues no all-bank precharge. After a refresh every bank counts as closed.
- R10: `req_ready` is low on every cycle that carries a non-NOP command. Each accepted request is followed on the next cycle by a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands change on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle with no refresh pending; request taken when both are high |
| req_write | input | 1 | 1 for write, 0 for read |
| req_autopre | input | 1 | Close the bank together with the column access |
| req_addr | input | 23 | Flat word address {row, bank, column} |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank select |
| a | output | 12 | Row, column/flag or precharge-scope address |

## Verification
The bench builds the sequencer with T_RCD = 3, T_RP = 2, T_RFC = 5 and REF_INT = 300. These distinct small delays make every required gap identifiable in a short run, and a misplaced wait shows up as a wrong count. The short refresh interval lets several refreshes land in the middle of request traffic. The spacing between refreshes, the all-bank precharge ahead of each refresh and the reopening of banks closed by it can therefore all be observed within about a thousand cycles.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

    localparam int ROW_W  = 12;
    localparam int BANK_W = 2;
    localparam int COL_W  = 9;
    localparam int NBANK  = 1 << BANK_W;
    localparam int ADDR_W = ROW_W + BANK_W + COL_W;
    localparam int AP_BIT = 8;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_NOP = 4'b0111,
        CMD_ACT = 4'b0011,
        CMD_RD  = 4'b0101,
        CMD_WR  = 4'b0100,
        CMD_PRE = 4'b0010,
        CMD_REF = 4'b0001
    } cmd_e;

    typedef struct packed {
        logic [ROW_W-1:0]  row;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
    } dram_addr_t;

    typedef enum logic [2:0] {
        S_IDLE, S_WAIT, S_PRE, S_ACT, S_CAS, S_PREA, S_REF
    } seq_st_e;

    // Column placement on the address bus: bit 8 is the precharge flag.
    function automatic logic [ROW_W-1:0] cas_addr(input logic [COL_W-1:0] col,
                                                  input logic ap);
        logic [ROW_W-1:0] v;
        v          = '0;
        v[7:0]     = col[7:0];
        v[AP_BIT]  = ap;
        v[9]       = col[8];
        return v;
    endfunction

endpackage

// File: rtl/dram_addr_split.sv
module dram_addr_split
    import dram_seq_pkg::*;
(
    input  logic [ADDR_W-1:0] flat,
    output dram_addr_t        fields
);

    always_comb begin
        fields = dram_addr_t'(flat);
    end

endmodule

// File: rtl/dram_bank_table.sv
module dram_bank_table #(
    parameter int NB = 4,
    parameter int RW = 12,
    localparam int BW = $clog2(NB)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 act_en,
    input  logic [BW-1:0]        act_bank,
    input  logic [RW-1:0]        act_row,
    input  logic                 close_en,
    input  logic [BW-1:0]        close_bank,
    input  logic                 close_all,
    output logic [NB-1:0]        open_o,
    output logic [NB-1:0][RW-1:0] rows_o
);

    for (genvar g = 0; g < NB; g++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                open_o[g] <= 1'b0;
                rows_o[g] <= '0;
            end else if (close_all || (close_en && close_bank == BW'(g))) begin
                open_o[g] <= 1'b0;
            end else if (act_en && act_bank == BW'(g)) begin
                open_o[g] <= 1'b1;
                rows_o[g] <= act_row;
            end
        end
    end

endmodule

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
    parameter int INTERVAL = 975,
    localparam int CW = $clog2(INTERVAL + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic ack,
    output logic pending
);

    logic [CW-1:0] cnt;
    logic          expire;

    assign expire = (cnt == CW'(INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            pending <= 1'b0;
        end else begin
            cnt <= expire ? '0 : cnt + 1'b1;
            if (expire)
                pending <= 1'b1;
            else if (ack)
                pending <= 1'b0;
        end
    end

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
        (pending && !ack) |=> pending); // R8

endmodule

// File: rtl/dram_cmd_seq.sv
module dram_cmd_seq
    import dram_seq_pkg::*;
#(
    parameter int T_RCD   = 4,
    parameter int T_RP    = 4,
    parameter int T_RFC   = 20,
    parameter int REF_INT = 975
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_autopre,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BANK_W-1:0] ba,
    output logic [ROW_W-1:0]  a
);

    localparam int MAXD_A = (T_RCD > T_RP) ? T_RCD : T_RP;
    localparam int MAXD   = (MAXD_A > T_RFC) ? MAXD_A : T_RFC;
    localparam int WCW    = $clog2(MAXD + 1);
    localparam logic [WCW-1:0] D_RCD = WCW'(T_RCD);
    localparam logic [WCW-1:0] D_RP  = WCW'(T_RP);
    localparam logic [WCW-1:0] D_RFC = WCW'(T_RFC);
    localparam logic [WCW-1:0] D_ONE = WCW'(1);

    seq_st_e                     state, after, tgt;
    logic [WCW-1:0]              wcnt, dly;
    dram_addr_t                  in_f, cur;
    logic                        cur_wr, cur_ap;
    logic [NBANK-1:0]            bank_open;
    logic [NBANK-1:0][ROW_W-1:0] bank_rows;
    logic                        any_open, hit, ref_pend, ref_ack;
    logic                        act_en, close_en, close_all;
    cmd_e                        cmd;

    dram_addr_split u_split (
        .flat   (req_addr),
        .fields (in_f)
    );

    dram_bank_table #(.NB(NBANK), .RW(ROW_W)) u_tab (
        .clk        (clk),
        .rst        (rst),
        .act_en     (act_en),
        .act_bank   (cur.bank),
        .act_row    (cur.row),
        .close_en   (close_en),
        .close_bank (cur.bank),
        .close_all  (close_all),
        .open_o     (bank_open),
        .rows_o     (bank_rows)
    );

    dram_refresh_timer #(.INTERVAL(REF_INT)) u_ref (
        .clk     (clk),
        .rst     (rst),
        .ack     (ref_ack),
        .pending (ref_pend)
    );

    assign any_open  = |bank_open;
    assign hit       = bank_open[in_f.bank] && (bank_rows[in_f.bank] == in_f.row);
    assign req_ready = (state == S_IDLE) && !ref_pend;
    assign act_en    = (state == S_ACT);
    assign close_en  = (state == S_PRE) || ((state == S_CAS) && cur_ap);
    assign close_all = (state == S_PREA);
    assign ref_ack   = (state == S_REF);

    // Command and bus contents per state
    always_comb begin
        cmd = CMD_NOP;
        ba  = '0;
        a   = '0;
        unique case (state)
            S_PRE:  begin cmd = CMD_PRE; ba = cur.bank; end
            S_ACT:  begin cmd = CMD_ACT; ba = cur.bank; a = cur.row; end
            S_CAS:  begin
                cmd = cur_wr ? CMD_WR : CMD_RD;
                ba  = cur.bank;
                a   = cas_addr(cur.col, cur_ap);
            end
            S_PREA: begin cmd = CMD_PRE; a[AP_BIT] = 1'b1; end
            S_REF:  cmd = CMD_REF;
            default: ;
        endcase
    end

    assign {cs_n, ras_n, cas_n, we_n} = cmd;

    // Delay that follows each command, and the state after it
    always_comb begin
        dly = D_ONE;
        tgt = S_IDLE;
        unique case (state)
            S_PRE:  begin dly = D_RP;  tgt = S_ACT; end
            S_ACT:  begin dly = D_RCD; tgt = S_CAS; end
            S_CAS:  begin dly = cur_ap ? D_RP : D_ONE; tgt = S_IDLE; end
            S_PREA: begin dly = D_RP;  tgt = S_REF; end
            S_REF:  begin dly = D_RFC; tgt = S_IDLE; end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            after  <= S_IDLE;
            wcnt   <= '0;
            cur    <= '0;
            cur_wr <= 1'b0;
            cur_ap <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (ref_pend) begin
                        state <= any_open ? S_PREA : S_REF;
                    end else if (req_valid) begin
                        cur    <= in_f;
                        cur_wr <= req_write;
                        cur_ap <= req_autopre;
                        if (hit)
                            state <= S_CAS;
                        else if (bank_open[in_f.bank])
                            state <= S_PRE;
                        else
                            state <= S_ACT;
                    end
                end
                S_WAIT: begin
                    wcnt <= wcnt - 1'b1;
                    if (wcnt == D_ONE)
                        state <= after;
                end
                default: begin
                    if (dly > D_ONE) begin
                        state <= S_WAIT;
                        wcnt  <= dly - 1'b1;
                        after <= tgt;
                    end else begin
                        state <= tgt;
                    end
                end
            endcase
        end
    end

    AST_ACCEPT_ISSUES: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (!req_ready && cmd != CMD_NOP)); // R10

    AST_CAS_ROW_OPEN: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_RD || cmd == CMD_WR) |-> (bank_open[ba] && bank_rows[ba] == cur.row)); // R3

    AST_ACT_BANK_CLOSED: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_ACT) |-> !bank_open[ba]); // R5

    AST_REF_ALL_CLOSED: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_REF) |-> !any_open); // R9

endmodule

// File: tb/dram_cmd_seq_bench.sv
module dram_cmd_seq_bench;
    import dram_seq_pkg::*;

    localparam int T_RCD   = 3;
    localparam int T_RP    = 2;
    localparam int T_RFC   = 5;
    localparam int REF_INT = 300;
    localparam int SLACK   = 30;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic              req_autopre = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              cs_n, ras_n, cas_n, we_n;
    logic [BANK_W-1:0] ba;
    logic [ROW_W-1:0]  a;

    always #4 clk = ~clk;

    dram_cmd_seq #(.T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC), .REF_INT(REF_INT)) u_dram_cmd_seq (
        .clk, .rst, .req_valid, .req_ready, .req_write, .req_autopre, .req_addr,
        .cs_n, .ras_n, .cas_n, .we_n, .ba, .a
    );

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    int last_cyc = 0;
    int last_ref_cyc = 0;
    int ref_count = 0;
    bit last_was_prea = 0;
    bit last_was_ref = 0;
    bit done = 0;

    logic [17:0] exp_word[$];
    int          exp_gap[$];
    string       exp_tag[$];

    bit             mopen[NBANK];
    logic [ROW_W-1:0] mrow[NBANK];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic bit model_any_open();
        bit r = 0;
        for (int i = 0; i < NBANK; i++) r |= mopen[i];
        return r;
    endfunction

    function automatic logic [17:0] mk(input logic [3:0] c, input logic [1:0] b, input logic [11:0] ad);
        return {c, b, ad};
    endfunction

    task automatic push(input logic [17:0] w, input int gap, input string tag);
        exp_word.push_back(w);
        exp_gap.push_back(gap);
        exp_tag.push_back(tag);
    endtask

    // Driver: waits for ready, predicts the command sequence, then presents the request
    task automatic do_req(input bit wr, input bit ap, input logic [1:0] bank,
                          input logic [11:0] row, input logic [8:0] col, input string tag);
        logic [11:0] ca;
        logic [3:0]  cc;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        ca = 12'h000;
        ca[7:0] = col[7:0];
        ca[9]   = col[8];
        ca[8]   = ap;
        cc = wr ? 4'b0100 : 4'b0101;
        if (mopen[bank] && mrow[bank] == row) begin
            push(mk(cc, bank, ca), 0, tag);
        end else if (mopen[bank]) begin
            push(mk(4'b0010, bank, 12'h000), 0, tag);
            push(mk(4'b0011, bank, row), T_RP, tag);
            push(mk(cc, bank, ca), T_RCD, tag);
        end else begin
            push(mk(4'b0011, bank, row), 0, tag);
            push(mk(cc, bank, ca), T_RCD, tag);
        end
        mopen[bank] = !ap;
        mrow[bank]  = row;
        req_valid   = 1'b1;
        req_write   = wr;
        req_autopre = ap;
        req_addr    = {row, bank, col};
        @(negedge clk);
        req_valid   = 1'b0;
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        logic [17:0] w;
        logic [3:0]  c;
        if (!rst && !done) begin
            cyc++;
            w = {cs_n, ras_n, cas_n, we_n, ba, a};
            c = w[17:14];
            if (c != 4'b0111) begin
                chk(req_ready == 1'b0, "R10 ready during command", {31'd0, req_ready}, 32'd0);
                if (last_was_ref)
                    chk(cyc - last_cyc >= T_RFC, "R9 gap after refresh", cyc - last_cyc, T_RFC);
                if (c == 4'b0010 && a[8]) begin
                    chk(model_any_open(), "R9 all-bank precharge with banks open", 0, 1);
                    for (int i = 0; i < NBANK; i++) mopen[i] = 0;
                    last_was_prea = 1;
                    last_was_ref  = 0;
                end else if (c == 4'b0001) begin
                    chk(!model_any_open(), "R9 refresh with banks closed", 1, 0);
                    if (last_was_prea)
                        chk(cyc - last_cyc == T_RP, "R9 precharge-all to refresh gap", cyc - last_cyc, T_RP);
                    chk((cyc - last_ref_cyc <= REF_INT + SLACK) && (cyc - last_ref_cyc >= REF_INT - SLACK),
                        "R8 refresh spacing", cyc - last_ref_cyc, REF_INT);
                    last_ref_cyc = cyc;
                    ref_count++;
                    last_was_prea = 0;
                    last_was_ref  = 1;
                end else begin
                    if (exp_word.size() == 0) begin
                        chk(0, "R3 unexpected command", {14'd0, w}, 32'd0);
                    end else begin
                        logic [17:0] ew;
                        int eg;
                        string et;
                        ew = exp_word.pop_front();
                        eg = exp_gap.pop_front();
                        et = exp_tag.pop_front();
                        chk(w == ew, et, {14'd0, w}, {14'd0, ew});
                        if (eg != 0)
                            chk(cyc - last_cyc == eg, {et, " gap"}, cyc - last_cyc, eg);
                    end
                    last_was_prea = 0;
                    last_was_ref  = 0;
                end
                last_cyc = cyc;
            end
            if (cyc > 20000) begin
                nfail++;
                $display("FAIL watchdog: actual cycle %0d expected below 20000", cyc);
                $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
                $finish;
            end
        end
    end

    initial begin
        for (int i = 0; i < NBANK; i++) begin
            mopen[i] = 0;
            mrow[i]  = '0;
        end
        repeat (3) @(negedge clk);
        chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1 NOP in reset", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
        chk(req_ready == 1'b1, "R1 ready in reset", req_ready, 1);
        @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1 NOP after reset", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
        chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);

        do_req(1, 0, 2'd0, 12'h005, 9'h003, "R3 closed bank write");
        do_req(0, 0, 2'd0, 12'h005, 9'h1FF, "R4 row hit read R6");
        do_req(1, 0, 2'd0, 12'h009, 9'h001, "R5 row miss");
        do_req(0, 1, 2'd1, 12'hFFF, 9'h100, "R6 auto precharge flag R2");
        do_req(0, 0, 2'd1, 12'hFFF, 9'h002, "R7 reopen after auto precharge");
        do_req(1, 0, 2'd2, 12'h0A5, 9'h0AA, "R2 bank two");
        do_req(0, 0, 2'd3, 12'h5A0, 9'h155, "R2 bank three");
        do_req(0, 0, 2'd3, 12'h5A0, 9'h000, "R4 hit bank three");

        while (ref_count < 1) @(negedge clk);
        do_req(0, 0, 2'd0, 12'h009, 9'h001, "R9 bank closed by refresh");

        for (int i = 0; i < 40; i++) begin
            do_req(i[0], (i % 5) == 0, 2'(i % 4), 12'((i / 3) * 37), 9'(i * 13), "R5 mixed traffic");
        end

        while (ref_count < 3 || exp_word.size() != 0) @(negedge clk);
        repeat (T_RFC + 2) @(negedge clk);
        chk(exp_word.size() == 0, "R10 all predicted commands seen", exp_word.size(), 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule